// File: doc/BRIEF.md
# Bus Access Dead-Time Throttle

This block sits between a bus master's request logic and its bus interface and decides only when a new transaction may begin. After each transaction finishes, it holds off the next one for a programmable number of idle clock cycles. This limits the share of bus bandwidth the master can take. Addressing, data and protocol encoding pass around the block untouched.

The control is a three-state machine. In `ST_OPEN` the bus is free: the throttle reports ready and passes a request straight through as an issue pulse. `ST_BUSY` covers one outstanding transaction and lasts until the bus reports completion. `ST_HOLD` is the enforced idle gap, counted down from a captured copy of the dead-time value.

The transitions are:
- `OPEN→BUSY` on a request.
- `BUSY→HOLD` on completion when throttling is on and the gap is non-zero.
- `BUSY→OPEN` on completion otherwise.
- `HOLD→OPEN` when the last gap cycle is counted or throttling is switched off.

Top module: `bus_gap_throttle`

## Requirements
- R1: After reset the throttle is in `ST_OPEN`: `ready_o` is 1 and `issue_o` is 0 while `req_i` is 0.
- R2: In `ST_OPEN`, `ready_o` is 1 and `issue_o` equals `req_i` in the same cycle, so the first request after reset or after `throttle_en` is set is never delayed.
- R3: Once `issue_o` has pulsed, only one transaction is outstanding. `ready_o` and `issue_o` stay 0 until a cycle with `done_i` = 1. A `done_i` pulse while no transaction is outstanding is ignored.
- R4: With `throttle_en` = 1 and `gap_cycles` = N > 0, take `done_i` in cycle t. Then `ready_o` is 0 in cycles t+1 through t+N and 1 in cycle t+N+1, giving exactly N idle cycles.
- R5: If `gap_cycles` = 0 or `throttle_en` = 0 when `done_i` arrives, `ready_o` is 1 in the very next cycle (back-to-back transactions).
- R6: The gap length is taken from `gap_cycles` in the cycle `done_i` is seen. Changing `gap_cycles` during the gap neither shortens nor lengthens it; the new value applies from the next completion.
- R7: A request held during the gap stays pending and is issued in the first cycle `ready_o` returns to 1.
- R8: Clearing `throttle_en` during a gap ends it. `ready_o` is 1 in the following cycle.
- R9: The largest value 255 gives a full gap of 255 idle cycles with no wrap of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| throttle_en | input | 1 | Enables gap insertion |
| gap_cycles | input | 8 | Minimum idle cycles between transactions |
| req_i | input | 1 | Master wants to start a transaction |
| done_i | input | 1 | Bus reports the outstanding transaction finished |
| issue_o | output | 1 | Start the transaction on the bus this cycle |
| ready_o | output | 1 | Throttle can accept a request this cycle |

## Verification
Several properties are checked on every cycle:
- Only one transaction is outstanding at a time.
- An issue always moves the machine into the busy state.
- The gap counter reloads and decrements correctly.
- Clearing the enable ends a gap.
- A zero or disabled gap reopens at once.
- A separate idle-cycle tally confirms that no throttled issue comes before the captured gap has elapsed.

Some behaviours only the bench scenarios can show: the exact cycle in which ready returns, that a mid-gap change to `gap_cycles` leaves the running gap alone, that a held request is granted in the first ready cycle, and the full 255-cycle gap.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } thr_state_t;
endpackage

// File: rtl/throttle_gap_ctr.sv
module throttle_gap_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // captured gap length: written only when a gap starts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val)); // R6
    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE); // R9
endmodule

// File: rtl/throttle_fsm.sv
module throttle_fsm
    import throttle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       req,
    input  logic       done,
    input  logic       gap_zero,
    input  logic       gap_last,
    output thr_state_t state_o,
    output logic       ready_o,
    output logic       issue_o,
    output logic       gap_load,
    output logic       gap_step
);
    thr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (req)  state_d = ST_BUSY;
            ST_BUSY: if (done) state_d = (en && !gap_zero) ? ST_HOLD : ST_OPEN;
            ST_HOLD: if (!en || gap_last) state_d = ST_OPEN;
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        ready_o  = 1'b0;
        issue_o  = 1'b0;
        gap_load = 1'b0;
        gap_step = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                ready_o = 1'b1;
                issue_o = req;
            end
            ST_BUSY: gap_load = done && en && !gap_zero;
            ST_HOLD: gap_step = en;
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (!issue_o && !ready_o)); // R3
    AST_ISSUE_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |=> (state_q == ST_BUSY)); // R3
    AST_DISABLE_ENDS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !en) |=> ready_o); // R8
    AST_ZERO_GAP_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && done && (!en || gap_zero)) |=> ready_o); // R5
endmodule

// File: rtl/bus_gap_throttle.sv
module bus_gap_throttle
    import throttle_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             throttle_en,
    input  logic [GAP_W-1:0] gap_cycles,
    input  logic             req_i,
    input  logic             done_i,
    output logic             issue_o,
    output logic             ready_o
);
    localparam logic [GAP_W-1:0] SAT = {GAP_W{1'b1}};

    thr_state_t state;
    logic       gap_load, gap_step, gap_last;
    logic       gap_zero;

    assign gap_zero = (gap_cycles == '0);

    throttle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (throttle_en),
        .req      (req_i),
        .done     (done_i),
        .gap_zero (gap_zero),
        .gap_last (gap_last),
        .state_o  (state),
        .ready_o  (ready_o),
        .issue_o  (issue_o),
        .gap_load (gap_load),
        .gap_step (gap_step)
    );

    throttle_gap_ctr #(.CNT_W(GAP_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_cycles),
        .step     (gap_step),
        .last     (gap_last)
    );

    // independent tally of idle cycles since the last completion (checking only)
    logic [GAP_W-1:0] idle_run;
    logic [GAP_W-1:0] held_gap;
    logic             held_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_run <= '0;
            held_gap <= '0;
            held_vld <= 1'b0;
        end else begin
            if (state == ST_BUSY && done_i) begin
                idle_run <= '0;
                held_gap <= gap_cycles;
                held_vld <= throttle_en;
            end else begin
                if (idle_run != SAT) idle_run <= idle_run + 1'b1;
                if (!throttle_en) held_vld <= 1'b0;
            end
        end
    end

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && throttle_en && held_vld) |-> (idle_run >= held_gap)); // R4
    AST_RESET_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ready_o); // R1
endmodule

// File: tb/bus_gap_throttle_tb_top.sv
module bus_gap_throttle_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       throttle_en = 1'b0;
    logic [7:0] gap_cycles = '0;
    logic       req_i = 1'b0;
    logic       done_i = 1'b0;
    logic       issue_o, ready_o;

    int checks = 0;
    int errors = 0;

    // reference model state: 0 open, 1 busy, 2 hold
    int       ms = 0;
    int       mcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_gap_throttle dut_i (
        .clk(clk), .rst_n(rst_n), .throttle_en(throttle_en),
        .gap_cycles(gap_cycles), .req_i(req_i), .done_i(done_i),
        .issue_o(issue_o), .ready_o(ready_o)
    );

    function automatic logic exp_ready(int s);
        return s == 0;
    endfunction

    function automatic logic exp_issue(int s, logic r);
        return (s == 0) && r;
    endfunction

    function automatic string auto_tag(int s);
        if (s == 0) return "R2";
        if (s == 1) return "R3";
        return "R4";
    endfunction

    task automatic check1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // inputs already driven; compare, then advance the model across the edge
    task automatic step(string tag);
        #1;
        check1(tag == "" ? auto_tag(ms) : tag, "ready_o", ready_o, exp_ready(ms));
        check1(tag == "" ? auto_tag(ms) : tag, "issue_o", issue_o, exp_issue(ms, req_i));
        @(posedge clk);
        case (ms)
            0: if (req_i) ms = 1;
            1: if (done_i) begin
                   if (throttle_en && gap_cycles != 0) begin ms = 2; mcnt = gap_cycles; end
                   else ms = 0;
               end
            default: begin
                if (!throttle_en || mcnt == 1) ms = 0;
                else mcnt = mcnt - 1;
            end
        endcase
        @(negedge clk);
    endtask

    task automatic drive(logic e, logic [7:0] g, logic r, logic d);
        throttle_en = e; gap_cycles = g; req_i = r; done_i = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005eed1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        drive(1'b0, 8'd0, 1'b0, 1'b0);
        step("R1");

        // R2: first request after enable goes out at once
        drive(1'b1, 8'd3, 1'b1, 1'b0);
        step("R2");
        // R3: busy, stray request blocked
        drive(1'b1, 8'd3, 1'b1, 1'b0);
        step("R3");
        // completion with request held: R4 gap of 3 then R7 grant
        drive(1'b1, 8'd3, 1'b1, 1'b1);
        step("R3");
        drive(1'b1, 8'd3, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step("R4");
        step("R7");
        // R6: capture 5, change to 1 mid gap
        drive(1'b1, 8'd5, 1'b0, 1'b1);
        step("R6");
        drive(1'b1, 8'd1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step("R6");
        // R3: done while open is ignored
        drive(1'b1, 8'd1, 1'b0, 1'b1);
        step("R3");
        drive(1'b1, 8'd1, 1'b0, 1'b0);
        step("R3");
        // R8: disable mid gap
        drive(1'b1, 8'd10, 1'b1, 1'b0);
        step("R2");
        drive(1'b1, 8'd10, 1'b0, 1'b1);
        step("R3");
        drive(1'b1, 8'd10, 1'b0, 1'b0);
        step("R8");
        drive(1'b0, 8'd10, 1'b0, 1'b0);
        step("R8");
        step("R8");
        // R5: zero gap and disabled
        drive(1'b1, 8'd0, 1'b1, 1'b0);
        step("R2");
        drive(1'b1, 8'd0, 1'b0, 1'b1);
        step("R5");
        drive(1'b1, 8'd0, 1'b1, 1'b0);
        step("R5");
        drive(1'b0, 8'd7, 1'b0, 1'b1);
        step("R5");
        drive(1'b0, 8'd7, 1'b0, 1'b0);
        step("R5");
        // R9: full gap 255
        drive(1'b1, 8'd255, 1'b1, 1'b0);
        step("R2");
        drive(1'b1, 8'd255, 1'b1, 1'b1);
        step("R9");
        drive(1'b1, 8'd255, 1'b1, 1'b0);
        for (int i = 0; i < 256; i++) step("R9");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic e;
            logic [7:0] g;
            e = ($urandom % 10) != 0;
            g = (($urandom % 8) == 0) ? 8'($urandom % 7) : gap_cycles;
            drive(e, g, ($urandom % 3) != 0, ($urandom % 3) == 0);
            step("");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule